// File: doc/BRIEF.md
# Dual-Processor Mailbox with Doorbells

This peripheral sits between two processors, called side A and side B, that share one clock. Each side has its own simple register port, made of a word address, a write strobe, write data and combinational read data. Through that port a side can leave short messages in a bank of shared 32-bit words. It can also ring doorbells: interrupt lines that raise a pending bit toward the peer, or toward itself.

Doorbell state is a single 32-bit status word. The upper half holds the 16 lines pending toward side A and the lower half holds the 16 lines pending toward side B. Both sides see the same status, clear and mask layout.

The generate register is seen relative to the writer. Its low half rings the peer and its high half re-arms the writer's own lines. A masked line still latches its pending bit, so software can poll the line and clear it without taking an interrupt. Each side's interrupt output is registered. A self-clearing control bit returns the whole block to its reset state.

Top module: `duo_mailbox`

## Requirements
- R1: After reset all pending bits are 0, both mask halves read all ones, every message word reads 0, the control word reads 0 and both interrupt outputs are 0.
- R2: Writing the generate register (word address 0x01) sets pending bits; zero bits have no effect. From side A, bits 15:0 set status bits 15:0 and bits 31:16 set status bits 31:16. From side B, bits 15:0 set status bits 31:16 and bits 31:16 set status bits 15:0. Status (0x04) is read-only, with bits 31:16 toward A and bits 15:0 toward B.
- R3: The clear register (0x02) is write-one-to-clear in status-word bit positions from either side; bits written as 0 leave their pending bits unchanged.
- R4: The mask register (0x03) is read/write with status-word layout. When both sides write it in the same cycle, side A's value is taken.
- R5: A masked line still latches its pending bit in status and produces no interrupt.
- R6: `a_irq` is the OR over status bits 31:16 that are pending and unmasked; `b_irq` is the same over bits 15:0. Each output follows the pending and mask state with one clock of latency.
- R7: When a set and a clear reach the same pending bit in one cycle, the bit ends up set.
- R8: Word addresses 0x40 to 0x7F are 64 message words, readable and writable from both sides. When both sides write the same word in one cycle, side A's data is stored.
- R9: Writing 1 to bit 0 of the control register (0x00) makes that bit read 1 for one cycle. On the next clock every register returns to its R1 value and the bit reads 0 again.
- R10: Unmapped addresses read 0, and writes to them or to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 7 | Side A word address |
| a_we | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from a_addr |
| b_addr | input | 7 | Side B word address |
| b_we | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from b_addr |
| a_irq | output | 1 | Registered doorbell interrupt toward side A |
| b_irq | output | 1 | Registered doorbell interrupt toward side B |

## Verification
Two functions can fall in the same cycle: one side clearing a pending bit while the other side rings that same line, and both sides writing the same message word or the mask register. The bench provokes each case by driving both ports in one clock. It judges the outcome by reading status, mask or the message word back through a port in the next cycle. A lost doorbell or the wrong side's data shows up in that read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Word offsets of the doorbell/control registers in the lower address half.
   typedef enum logic [2:0] {
      OFS_CTRL = 3'd0,
      OFS_GEN  = 3'd1,
      OFS_CLR  = 3'd2,
      OFS_MASK = 3'd3,
      OFS_STAT = 3'd4
   } mbx_ofs_e;

   localparam int unsigned NUM_SIDES = 2;
   localparam int unsigned GRP_TO_A  = 0;  // upper status half
   localparam int unsigned GRP_TO_B  = 1;  // lower status half

endpackage

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
   parameter int unsigned LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic [LINES-1:0] set_v,
   input  logic [LINES-1:0] clr_v,
   input  logic             mask_we,
   input  logic [LINES-1:0] mask_wd,
   output logic [LINES-1:0] pend_q,
   output logic [LINES-1:0] mask_q,
   output logic             irq_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '1;
         irq_q  <= 1'b0;
      end else if (srst) begin
         pend_q <= '0;
         mask_q <= '1;
         irq_q  <= 1'b0;
      end else begin
         // a set on the same bit overrides a clear
         pend_q <= (pend_q & ~clr_v) | set_v;
         if (mask_we) begin
            mask_q <= mask_wd;
         end
         irq_q <= |(pend_q & ~mask_q);
      end
   end

endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank #(
   parameter int unsigned WORDS = 64,
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             a_we,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [WIDTH-1:0] a_wd,
   output logic [WIDTH-1:0] a_rd,
   input  logic             b_we,
   input  logic [IDX_W-1:0] b_idx,
   input  logic [WIDTH-1:0] b_wd,
   output logic [WIDTH-1:0] b_rd
);

   logic [WIDTH-1:0] words_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
      end else if (srst) begin
         for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
      end else begin
         for (int w = 0; w < WORDS; w++) begin
            if (a_we && (a_idx == IDX_W'(w))) begin
               words_q[w] <= a_wd;
            end else if (b_we && (b_idx == IDX_W'(w))) begin
               words_q[w] <= b_wd;
            end
         end
      end
   end

   assign a_rd = words_q[a_idx];
   assign b_rd = words_q[b_idx];

endmodule

// File: rtl/mbx_softrst.sv
module mbx_softrst (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr,
   output logic srst
);

   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (req_q) begin
         req_q <= 1'b0;       // self-clear once the reset has been applied
      end else if (req_wr) begin
         req_q <= 1'b1;
      end
   end

   assign srst = req_q;

endmodule

// File: rtl/duo_mailbox.sv
module duo_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned LINES     = 16,
   parameter int unsigned MSG_WORDS = 64,
   parameter int unsigned ADDR_W    = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    a_addr,
   input  logic                 a_we,
   input  logic [2*LINES-1:0]   a_wdata,
   output logic [2*LINES-1:0]   a_rdata,
   input  logic [ADDR_W-1:0]    b_addr,
   input  logic                 b_we,
   input  logic [2*LINES-1:0]   b_wdata,
   output logic [2*LINES-1:0]   b_rdata,
   output logic                 a_irq,
   output logic                 b_irq
);

   localparam int unsigned DATA_W    = 2 * LINES;
   localparam int unsigned MSG_IDX_W = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;

   if (LINES < 1 || LINES > 16) begin : g_bad_lines
      $error("duo_mailbox: LINES must lie in 1..16");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("duo_mailbox: ADDR_W must be at least 4");
   end
   if ((1 << MSG_IDX_W) != MSG_WORDS || MSG_WORDS > (1 << (ADDR_W - 1))) begin : g_bad_msg
      $error("duo_mailbox: MSG_WORDS must be a power of two fitting the upper address half");
   end

   // ---------------------------------------------------------------- ports
   logic [NUM_SIDES-1:0][ADDR_W-1:0] p_addr;
   logic [NUM_SIDES-1:0]             p_we;
   logic [NUM_SIDES-1:0][DATA_W-1:0] p_wdata;
   logic [NUM_SIDES-1:0][DATA_W-1:0] p_rdata;
   logic [NUM_SIDES-1:0][DATA_W-1:0] msg_rd;
   logic [NUM_SIDES-1:0]             p_ctrl, p_gen, p_clr, p_mask, p_msg;

   assign p_addr  = {b_addr, a_addr};
   assign p_we    = {b_we, a_we};
   assign p_wdata = {b_wdata, a_wdata};
   assign a_rdata = p_rdata[0];
   assign b_rdata = p_rdata[1];

   // doorbell group state: index 0 toward side A, index 1 toward side B
   logic [NUM_SIDES-1:0][LINES-1:0] grp_set, grp_clr, grp_pend, grp_mask;
   logic [NUM_SIDES-1:0]            grp_irq;
   logic                            srst;

   function automatic logic hit_reg(input logic [ADDR_W-1:0] ad, input mbx_ofs_e ofs);
      return (ad[ADDR_W-1:3] == '0) && (ad[2:0] == ofs);
   endfunction

   function automatic logic hit_msg(input logic [ADDR_W-1:0] ad);
      return ad[ADDR_W-1] && (int'(ad[ADDR_W-2:0]) < int'(MSG_WORDS));
   endfunction

   for (genvar p = 0; p < NUM_SIDES; p++) begin : g_side
      assign p_ctrl[p] = p_we[p] && hit_reg(p_addr[p], OFS_CTRL);
      assign p_gen[p]  = p_we[p] && hit_reg(p_addr[p], OFS_GEN);
      assign p_clr[p]  = p_we[p] && hit_reg(p_addr[p], OFS_CLR);
      assign p_mask[p] = p_we[p] && hit_reg(p_addr[p], OFS_MASK);
      assign p_msg[p]  = p_we[p] && hit_msg(p_addr[p]);

      always_comb begin
         p_rdata[p] = '0;
         if (hit_msg(p_addr[p])) begin
            p_rdata[p] = msg_rd[p];
         end else if (hit_reg(p_addr[p], OFS_CTRL)) begin
            p_rdata[p][0] = srst;
         end else if (hit_reg(p_addr[p], OFS_MASK)) begin
            p_rdata[p] = {grp_mask[GRP_TO_A], grp_mask[GRP_TO_B]};
         end else if (hit_reg(p_addr[p], OFS_STAT)) begin
            p_rdata[p] = {grp_pend[GRP_TO_A], grp_pend[GRP_TO_B]};
         end
      end
   end

   // ------------------------------------------------- set / clear steering
   always_comb begin
      grp_set = '0;
      grp_clr = '0;
      for (int p = 0; p < NUM_SIDES; p++) begin
         if (p_gen[p]) begin
            // upper half re-arms the writer's own lines, lower half rings the peer
            grp_set[p]     = grp_set[p]     | p_wdata[p][DATA_W-1:LINES];
            grp_set[1 - p] = grp_set[1 - p] | p_wdata[p][LINES-1:0];
         end
         if (p_clr[p]) begin
            grp_clr[GRP_TO_A] = grp_clr[GRP_TO_A] | p_wdata[p][DATA_W-1:LINES];
            grp_clr[GRP_TO_B] = grp_clr[GRP_TO_B] | p_wdata[p][LINES-1:0];
         end
      end
   end

   logic              mask_we;
   logic [DATA_W-1:0] mask_wd;
   assign mask_we = p_mask[0] | p_mask[1];
   assign mask_wd = p_mask[0] ? p_wdata[0] : p_wdata[1];   // side A has priority

   for (genvar g = 0; g < NUM_SIDES; g++) begin : g_grp
      mbx_doorbell #(.LINES(LINES)) u_bell (
         .clk     (clk),
         .rst_n   (rst_n),
         .srst    (srst),
         .set_v   (grp_set[g]),
         .clr_v   (grp_clr[g]),
         .mask_we (mask_we),
         .mask_wd ((g == GRP_TO_A) ? mask_wd[DATA_W-1:LINES] : mask_wd[LINES-1:0]),
         .pend_q  (grp_pend[g]),
         .mask_q  (grp_mask[g]),
         .irq_q   (grp_irq[g])
      );
   end

   assign a_irq = grp_irq[GRP_TO_A];
   assign b_irq = grp_irq[GRP_TO_B];

   // ------------------------------------------------------- message words
   mbx_msg_bank #(.WORDS(MSG_WORDS), .WIDTH(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .a_we  (p_msg[0]),
      .a_idx (p_addr[0][MSG_IDX_W-1:0]),
      .a_wd  (p_wdata[0]),
      .a_rd  (msg_rd[0]),
      .b_we  (p_msg[1]),
      .b_idx (p_addr[1][MSG_IDX_W-1:0]),
      .b_wd  (p_wdata[1]),
      .b_rd  (msg_rd[1])
   );

   // ----------------------------------------------------------- soft reset
   mbx_softrst u_srst (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_wr ((p_ctrl[0] && p_wdata[0][0]) || (p_ctrl[1] && p_wdata[1][0])),
      .srst   (srst)
   );

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
   parameter int unsigned LINES = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  srst,
   input logic [1:0][LINES-1:0] set_v,
   input logic [1:0][LINES-1:0] clr_v,
   input logic [1:0][LINES-1:0] pend_v,
   input logic [1:0][LINES-1:0] mask_v,
   input logic [1:0]            irq_v
);

   for (genvar g = 0; g < 2; g++) begin : g_chk
      // R6: interrupt follows the unmasked pending state one clock later
      p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(srst) |-> (irq_v[g] == $past(|(pend_v[g] & ~mask_v[g]))));

      // R7: a requested set is never lost, even against a clear
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!srst && (set_v[g] != '0)) |=> ((pend_v[g] & $past(set_v[g])) == $past(set_v[g])));

      // R3: a clear without a competing set removes the bit
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!srst && ((clr_v[g] & ~set_v[g]) != '0))
            |=> ((pend_v[g] & $past(clr_v[g] & ~set_v[g])) == '0));

      // R5: pending bits only drop through a clear or the soft reset
      p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !srst |=> ((~pend_v[g] & $past(pend_v[g]) & ~$past(clr_v[g])) == '0));

      // R9: soft reset restores reset values and releases itself
      p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
         srst |=> ((pend_v[g] == '0) && (mask_v[g] == '1) && !irq_v[g] && !srst));
   end

endmodule

bind duo_mailbox mbx_checker #(.LINES(LINES)) u_mbx_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .srst   (srst),
   .set_v  (grp_set),
   .clr_v  (grp_clr),
   .pend_v (grp_pend),
   .mask_v (grp_mask),
   .irq_v  (grp_irq)
);

// File: tb/test_duo_mailbox.sv
`timescale 1ns/1ps
module test_duo_mailbox;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  a_addr = '0, b_addr = '0;
   logic        a_we = 1'b0, b_we = 1'b0;
   logic [31:0] a_wdata = '0, b_wdata = '0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   duo_mailbox i_duo_mailbox (
      .clk(clk), .rst_n(rst_n),
      .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .a_irq(a_irq), .b_irq(b_irq)
   );

   localparam logic [6:0] A_CTRL = 7'h00, A_GEN = 7'h01, A_CLR = 7'h02,
                          A_MASK = 7'h03, A_STAT = 7'h04;

   // {req[3:0], is_read, side(0=A,1=B), addr[6:0], data[31:0]}
   localparam int NV = 18;
   localparam logic [44:0] VEC [NV] = '{
      {4'd8,  1'b0, 1'b0, 7'h40,  32'hDEADBEEF},   // R8 write A
      {4'd8,  1'b1, 1'b1, 7'h40,  32'hDEADBEEF},   // R8 read B
      {4'd8,  1'b0, 1'b1, 7'h7F,  32'h12345678},
      {4'd8,  1'b1, 1'b0, 7'h7F,  32'h12345678},
      {4'd2,  1'b0, 1'b0, A_GEN,  32'h0003_0005},  // R2 side A rings
      {4'd2,  1'b1, 1'b1, A_STAT, 32'h0003_0005},
      {4'd2,  1'b0, 1'b1, A_GEN,  32'h0010_0100},  // R2 side B rings
      {4'd2,  1'b1, 1'b0, A_STAT, 32'h0103_0015},
      {4'd3,  1'b0, 1'b1, A_CLR,  32'h0001_0004},  // R3 partial clear
      {4'd3,  1'b1, 1'b0, A_STAT, 32'h0102_0011},
      {4'd4,  1'b0, 1'b0, A_MASK, 32'h0000_FFFF},  // R4 mask write
      {4'd4,  1'b1, 1'b1, A_MASK, 32'h0000_FFFF},
      {4'd10, 1'b0, 1'b0, A_STAT, 32'hFFFF_FFFF},  // R10 status is read-only
      {4'd10, 1'b1, 1'b0, A_STAT, 32'h0102_0011},
      {4'd10, 1'b0, 1'b0, 7'h05,  32'hFFFF_FFFF},  // R10 unmapped
      {4'd10, 1'b1, 1'b0, 7'h05,  32'h0000_0000},
      {4'd3,  1'b0, 1'b1, A_CLR,  32'hFFFF_FFFF},  // R3 full clear
      {4'd3,  1'b1, 1'b0, A_STAT, 32'h0000_0000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr1(input bit side, input logic [6:0] ad, input logic [31:0] d);
      if (!side) begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
      else       begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
      @(posedge clk); @(negedge clk);
      a_we = 1'b0; b_we = 1'b0;
   endtask

   task automatic wr2(input logic [6:0] aad, input logic [31:0] ad,
                      input logic [6:0] bad, input logic [31:0] bd);
      a_addr = aad; a_wdata = ad; a_we = 1'b1;
      b_addr = bad; b_wdata = bd; b_we = 1'b1;
      @(posedge clk); @(negedge clk);
      a_we = 1'b0; b_we = 1'b0;
   endtask

   task automatic rd(input bit side, input logic [6:0] ad, output logic [31:0] v);
      if (!side) a_addr = ad; else b_addr = ad;
      #1;
      v = side ? b_rdata : a_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 a_irq", {31'b0, a_irq}, 32'h0);
      check("R1 b_irq", {31'b0, b_irq}, 32'h0);
      rd(1'b0, A_STAT, v); check("R1 status", v, 32'h0);
      rd(1'b1, A_MASK, v); check("R1 mask", v, 32'hFFFF_FFFF);
      rd(1'b0, 7'h40, v);  check("R1 message", v, 32'h0);
      rd(1'b1, A_CTRL, v); check("R1 control", v, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [44:0] e;
         e = VEC[i];
         if (!e[40]) begin
            wr1(e[39], e[38:32], e[31:0]);
         end else begin
            rd(e[39], e[38:32], v);
            check($sformatf("R%0d vector %0d", e[44:41], i), v, e[31:0]);
         end
      end

      // R6: side B rings A line 0, A unmasked; one clock latency
      wr1(1'b1, A_GEN, 32'h0000_0001);
      check("R6 a_irq latency", {31'b0, a_irq}, 32'h0);
      @(negedge clk);
      check("R6 a_irq raised", {31'b0, a_irq}, 32'h1);
      check("R6 b_irq idle", {31'b0, b_irq}, 32'h0);

      // R5: B lines masked, pending still latches
      wr1(1'b0, A_GEN, 32'h0000_0002);
      @(negedge clk); @(negedge clk);
      check("R5 b_irq masked", {31'b0, b_irq}, 32'h0);
      rd(1'b1, A_STAT, v); check("R5 masked latch", v, 32'h0001_0002);
      wr1(1'b1, A_CLR, 32'h0000_0002);
      rd(1'b1, A_STAT, v); check("R5 poll clear", v, 32'h0001_0000);

      // R7: clear from A against ring from B on the same bit
      wr2(A_CLR, 32'h0001_0000, A_GEN, 32'h0000_0001);
      rd(1'b0, A_STAT, v); check("R7 set beats clear", v, 32'h0001_0000);
      wr1(1'b0, A_CLR, 32'h0001_0000);
      rd(1'b0, A_STAT, v); check("R3 lone clear", v, 32'h0);
      check("R6 a_irq lags clear", {31'b0, a_irq}, 32'h1);
      @(negedge clk);
      check("R6 a_irq dropped", {31'b0, a_irq}, 32'h0);

      // R4: concurrent mask writes, side A wins
      wr2(A_MASK, 32'h1234_0000, A_MASK, 32'hFFFF_FFFF);
      rd(1'b1, A_MASK, v); check("R4 mask priority", v, 32'h1234_0000);
      wr1(1'b0, A_MASK, 32'h0);
      wr1(1'b0, A_GEN, 32'h0000_0080);
      @(negedge clk);
      check("R6 b_irq raised", {31'b0, b_irq}, 32'h1);
      wr1(1'b1, A_CLR, 32'h0000_0080);

      // R8: both sides write the same message word
      wr2(7'h45, 32'hAAAA_5555, 7'h45, 32'h5555_AAAA);
      rd(1'b1, 7'h45, v); check("R8 message priority", v, 32'hAAAA_5555);

      // R9: soft reset
      wr1(1'b1, A_GEN, 32'h0000_0008);
      @(negedge clk);
      check("R9 pre a_irq", {31'b0, a_irq}, 32'h1);
      wr1(1'b1, A_CTRL, 32'h0000_0001);
      rd(1'b0, A_CTRL, v); check("R9 bit visible", v, 32'h1);
      rd(1'b0, A_STAT, v); check("R9 not yet applied", v, 32'h0008_0000);
      @(negedge clk);
      rd(1'b0, A_CTRL, v); check("R9 bit self-clears", v, 32'h0);
      rd(1'b0, A_STAT, v); check("R9 status cleared", v, 32'h0);
      rd(1'b1, A_MASK, v); check("R9 mask restored", v, 32'hFFFF_FFFF);
      rd(1'b1, 7'h40, v);  check("R9 message cleared", v, 32'h0);
      rd(1'b0, 7'h45, v);  check("R9 message cleared", v, 32'h0);
      check("R9 a_irq cleared", {31'b0, a_irq}, 32'h0);

      finish_run();
   end

endmodule